// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a set of already-synchronized input pins and turns selected pin activity into interrupt requests. Pins are grouped eight to a port and several ports to a bank. Each pin has its own trigger setting: active-low level, active-high level, rising edge, falling edge or any edge. A pin that sees its event sets a sticky status bit. Software clears status bits by writing ones to a clear register. A per-pin enable bit decides whether a pending status bit reaches the bank's interrupt line.

Software reaches the block through a simple 32-bit register bus. The bus has a write port and a separate read port whose data is combinational. Every port has a plain register and a masked alias for status, enable and trigger. The masked alias changes only the pins named in a mask byte, so software never needs a read-modify-write to touch a single pin.

Top module: `pin_event_irq`

## Requirements
- R1: A register address is bank*0x100 + register code*0x10 + port*4. The register codes are 0x4 status, 0x5 enable, 0x6 trigger and 0x7 clear. The masked aliases are 0xC status, 0xD enable and 0xE trigger, and each alias reads back the same value as its plain register. A write or read with a bank number of NUM_BANKS or more, a port number of PORTS_PER_BANK or more, nonzero address bits [1:0] or another register code has no effect and reads 0. The clear register reads 0.
- R2: The trigger register of a port holds three bits for pin n: bit n (high), bit n+8 (edge) and bit n+16 (any-edge). With edge set, any-edge selects both edges. Otherwise high selects rising and its absence selects falling. With edge clear, high selects active-high level and its absence selects active-low level, and any-edge is ignored. A plain trigger write loads all three fields.
- R3: In an edge mode, the status bit is set at the clock edge that follows a cycle in which the pin's sampled value differs from its value in the previous cycle in the selected direction. The pin's previous value is taken as 0 after reset.
- R4: In a level mode, the status bit is set at every clock edge at which the pin is at its active level, so a clear issued during that time leaves the bit set.
- R5: Writing the clear register clears the status bits at the positions of the ones in data bits [7:0]. Zero bits leave their status bits unchanged.
- R6: When a clear or a status write removes a bit in the same cycle that the pin detects an event, the status bit is set after that edge.
- R7: Status bits latch whether or not the pin is enabled.
- R8: Bank b's interrupt output is high exactly while at least one pin of that bank has both its status bit and its enable bit set. The output follows the registers with no extra delay.
- R9: A masked alias write uses data bits [15:8] as a per-pin mask. For masked pins, status or enable takes data bits [7:0]. A masked trigger write takes high from bits [7:0], edge from bits [23:16] and any-edge from bits [31:24]. Unmasked pins keep their values.
- R10: While reset is asserted, all status, enable and trigger bits are 0 and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinsIn | input | NUM_BANKS*PORTS_PER_BANK*8 | Synchronized pin levels, pin p of port q at bit q*8+p |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 32 | Combinational read data |
| irqOut | output | NUM_BANKS | One interrupt line per bank |

## Verification
The bench builds the block with two banks of four ports, which gives 64 pins and two interrupt lines. With this setting, a pending pin in one bank can be shown not to disturb the other bank's line. The 4-bit bank field then leaves fourteen bank codes unmapped, so random writes often miss and must be shown to change nothing. With only eight ports, random pin toggling and random register traffic reach every trigger mode, and the collisions between events and clears that come up in many combinations.

// File: rtl/pei_pkg.sv
package pei_pkg;

  localparam logic [3:0] RegStatus  = 4'h4;
  localparam logic [3:0] RegEnable  = 4'h5;
  localparam logic [3:0] RegTrig    = 4'h6;
  localparam logic [3:0] RegClear   = 4'h7;
  localparam logic [3:0] RegStatusM = 4'hC;
  localparam logic [3:0] RegEnableM = 4'hD;
  localparam logic [3:0] RegTrigM   = 4'hE;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_ENABLE,
    RD_TRIG
  } rdSel_e;

  // Write strobes from control to datapath, one port at a time.
  typedef struct packed {
    logic       wrStatus;
    logic       wrEnable;
    logic       wrTrig;
    logic       wrClear;
    logic [7:0] sel;       // pins touched (clear: pins cleared)
    logic [7:0] valHigh;   // status/enable value or trigger high field
    logic [7:0] valEdge;
    logic [7:0] valDelta;
  } strobe_t;

endpackage

// File: rtl/pei_ctrl.sv
module pei_ctrl
  import pei_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int PORTS_PER_BANK = 4,   // at most 4: port index is address bits [3:2]
  parameter int ADDR_W         = 12,
  localparam int NUM_PORTS     = NUM_BANKS * PORTS_PER_BANK,
  localparam int PORT_IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [31:0]           wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output strobe_t               strobe,
  output logic [NUM_PORTS-1:0]  portHit,
  output rdSel_e                rdSel,
  output logic [PORT_IDX_W-1:0] rdPort
);

  localparam int BANK_W = ADDR_W - 8;

  logic [BANK_W-1:0] wBank, rBank;
  logic [3:0]        wReg, rReg;
  logic [1:0]        wPort, rPort;
  logic              wrInRange, rdInRange, regKnown, wrGo;

  assign wBank = wrAddr[ADDR_W-1:8];
  assign wReg  = wrAddr[7:4];
  assign wPort = wrAddr[3:2];
  assign rBank = rdAddr[ADDR_W-1:8];
  assign rReg  = rdAddr[7:4];
  assign rPort = rdAddr[3:2];

  assign wrInRange = (int'(wBank) < NUM_BANKS) && (int'(wPort) < PORTS_PER_BANK)
                     && (wrAddr[1:0] == 2'b00);
  assign rdInRange = (int'(rBank) < NUM_BANKS) && (int'(rPort) < PORTS_PER_BANK)
                     && (rdAddr[1:0] == 2'b00);

  always_comb begin
    strobe   = '0;
    regKnown = 1'b1;
    case (wReg)
      RegStatus: begin
        strobe.wrStatus = 1'b1;
        strobe.sel      = 8'hFF;
        strobe.valHigh  = wrData[7:0];
      end
      RegStatusM: begin
        strobe.wrStatus = 1'b1;
        strobe.sel      = wrData[15:8];
        strobe.valHigh  = wrData[7:0];
      end
      RegEnable: begin
        strobe.wrEnable = 1'b1;
        strobe.sel      = 8'hFF;
        strobe.valHigh  = wrData[7:0];
      end
      RegEnableM: begin
        strobe.wrEnable = 1'b1;
        strobe.sel      = wrData[15:8];
        strobe.valHigh  = wrData[7:0];
      end
      RegTrig: begin
        strobe.wrTrig   = 1'b1;
        strobe.sel      = 8'hFF;
        strobe.valHigh  = wrData[7:0];
        strobe.valEdge  = wrData[15:8];
        strobe.valDelta = wrData[23:16];
      end
      RegTrigM: begin
        strobe.wrTrig   = 1'b1;
        strobe.sel      = wrData[15:8];
        strobe.valHigh  = wrData[7:0];
        strobe.valEdge  = wrData[23:16];
        strobe.valDelta = wrData[31:24];
      end
      RegClear: begin
        strobe.wrClear  = 1'b1;
        strobe.sel      = wrData[7:0];
      end
      default: regKnown = 1'b0;
    endcase
  end

  assign wrGo = wrEn && wrInRange && regKnown;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar p = 0; p < PORTS_PER_BANK; p++) begin : g_port
      assign portHit[b*PORTS_PER_BANK + p] = wrGo && (int'(wBank) == b) && (int'(wPort) == p);
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdInRange) begin
      case (rReg)
        RegStatus, RegStatusM: rdSel = RD_STATUS;
        RegEnable, RegEnableM: rdSel = RD_ENABLE;
        RegTrig,   RegTrigM:   rdSel = RD_TRIG;
        default:               rdSel = RD_NONE;
      endcase
    end
    rdPort = rdInRange ? PORT_IDX_W'(int'(rBank) * PORTS_PER_BANK + int'(rPort)) : '0;
  end

endmodule

// File: rtl/pei_datapath.sv
module pei_datapath
  import pei_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int PORTS_PER_BANK = 4,
  localparam int NUM_PORTS     = NUM_BANKS * PORTS_PER_BANK,
  localparam int NUM_PINS      = NUM_PORTS * 8,
  localparam int BANK_PINS     = PORTS_PER_BANK * 8,
  localparam int PORT_IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinsIn,
  input  strobe_t               strobe,
  input  logic [NUM_PORTS-1:0]  portHit,
  input  rdSel_e                rdSel,
  input  logic [PORT_IDX_W-1:0] rdPort,
  output logic [31:0]           rdData,
  output logic [NUM_BANKS-1:0]  irqOut,
  output logic [NUM_PINS-1:0]   statusQ,
  output logic [NUM_PINS-1:0]   enableQ,
  output logic [NUM_PINS-1:0]   trigHigh,
  output logic [NUM_PINS-1:0]   trigEdge,
  output logic [NUM_PINS-1:0]   trigDelta
);

  logic [NUM_PINS-1:0] prevQ, eventD;
  logic [NUM_PINS-1:0] statusD, enableD, highD, edgeD, deltaD;

  function automatic logic [7:0] mergeByte(input logic [7:0] cur, input logic hit,
                                           input logic [7:0] sel, input logic [7:0] val);
    return hit ? ((cur & ~sel) | (val & sel)) : cur;
  endfunction

  // Per-pin event detection against the previous sample.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall;
    assign rise = pinsIn[i] & ~prevQ[i];
    assign fall = ~pinsIn[i] & prevQ[i];
    assign eventD[i] = trigEdge[i]
                     ? (trigDelta[i] ? (rise | fall) : (trigHigh[i] ? rise : fall))
                     : (trigHigh[i] ? pinsIn[i] : ~pinsIn[i]);
  end

  // Per-port next state; events are merged last so they win.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [7:0] clrMask;
    assign clrMask = (portHit[p] && strobe.wrClear) ? strobe.sel : 8'h00;
    assign statusD[p*8 +: 8] =
      (mergeByte(statusQ[p*8 +: 8], portHit[p] && strobe.wrStatus, strobe.sel, strobe.valHigh)
       & ~clrMask) | eventD[p*8 +: 8];
    assign enableD[p*8 +: 8] =
      mergeByte(enableQ[p*8 +: 8], portHit[p] && strobe.wrEnable, strobe.sel, strobe.valHigh);
    assign highD[p*8 +: 8] =
      mergeByte(trigHigh[p*8 +: 8], portHit[p] && strobe.wrTrig, strobe.sel, strobe.valHigh);
    assign edgeD[p*8 +: 8] =
      mergeByte(trigEdge[p*8 +: 8], portHit[p] && strobe.wrTrig, strobe.sel, strobe.valEdge);
    assign deltaD[p*8 +: 8] =
      mergeByte(trigDelta[p*8 +: 8], portHit[p] && strobe.wrTrig, strobe.sel, strobe.valDelta);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= '0;
      statusQ   <= '0;
      enableQ   <= '0;
      trigHigh  <= '0;
      trigEdge  <= '0;
      trigDelta <= '0;
    end else begin
      prevQ     <= pinsIn;
      statusQ   <= statusD;
      enableQ   <= enableD;
      trigHigh  <= highD;
      trigEdge  <= edgeD;
      trigDelta <= deltaD;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign irqOut[b] = |(statusQ[b*BANK_PINS +: BANK_PINS] & enableQ[b*BANK_PINS +: BANK_PINS]);
  end

  always_comb begin
    case (rdSel)
      RD_STATUS: rdData = {24'h0, statusQ[{rdPort, 3'b000} +: 8]};
      RD_ENABLE: rdData = {24'h0, enableQ[{rdPort, 3'b000} +: 8]};
      RD_TRIG:   rdData = {8'h0, trigDelta[{rdPort, 3'b000} +: 8],
                           trigEdge[{rdPort, 3'b000} +: 8], trigHigh[{rdPort, 3'b000} +: 8]};
      default:   rdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pei_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int PORTS_PER_BANK = 4,
  parameter int ADDR_W         = 12,
  localparam int NUM_PORTS     = NUM_BANKS * PORTS_PER_BANK,
  localparam int NUM_PINS      = NUM_PORTS * 8,
  localparam int PORT_IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  pinsIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [31:0]          wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [31:0]          rdData,
  output logic [NUM_BANKS-1:0] irqOut
);

  strobe_t               strobe;
  logic [NUM_PORTS-1:0]  portHit;
  rdSel_e                rdSel;
  logic [PORT_IDX_W-1:0] rdPort;
  logic [NUM_PINS-1:0]   statusQ, enableQ, trigHigh, trigEdge, trigDelta;

  pei_ctrl #(
    .NUM_BANKS(NUM_BANKS), .PORTS_PER_BANK(PORTS_PER_BANK), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .strobe(strobe), .portHit(portHit), .rdSel(rdSel), .rdPort(rdPort)
  );

  pei_datapath #(
    .NUM_BANKS(NUM_BANKS), .PORTS_PER_BANK(PORTS_PER_BANK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .strobe(strobe), .portHit(portHit),
    .rdSel(rdSel), .rdPort(rdPort), .rdData(rdData), .irqOut(irqOut),
    .statusQ(statusQ), .enableQ(enableQ), .trigHigh(trigHigh),
    .trigEdge(trigEdge), .trigDelta(trigDelta)
  );

endmodule

// File: rtl/pei_checker.sv
module pei_checker #(
  parameter int NUM_BANKS      = 8,
  parameter int PORTS_PER_BANK = 4,
  localparam int NUM_PINS      = NUM_BANKS * PORTS_PER_BANK * 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PINS-1:0]  pinsIn,
  input logic                 wrEn,
  input logic [3:0]           wrReg,
  input logic [NUM_PINS-1:0]  statusQ,
  input logic [NUM_PINS-1:0]  enableQ,
  input logic [NUM_PINS-1:0]  trigHigh,
  input logic [NUM_PINS-1:0]  trigEdge,
  input logic [NUM_PINS-1:0]  trigDelta,
  input logic [NUM_BANKS-1:0] irqOut
);

  logic [NUM_PINS-1:0] prevSeen, levelHot, riseHot;
  logic                statusWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSeen <= '0;
    else       prevSeen <= pinsIn;
  end

  assign statusWrite = wrEn && (wrReg == 4'h4 || wrReg == 4'hC || wrReg == 4'h7);
  assign levelHot = ~trigEdge & ((trigHigh & pinsIn) | (~trigHigh & ~pinsIn));
  assign riseHot  = trigEdge & trigHigh & ~trigDelta & pinsIn & ~prevSeen;

  // R8: no enabled pin, no interrupt
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> (irqOut == '0));

  // R8: an interrupt needs a pending enabled pin
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> ((statusQ & enableQ) != '0));

  // R7: without status-side writes, status bits never fall
  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !statusWrite |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4 and R6: an active level sets status on the next edge, whatever is written
  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    (levelHot != '0) |=> ((statusQ & $past(levelHot)) == $past(levelHot)));

  // R3: a rising edge in rising mode sets status on the next edge
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    (riseHot != '0) |=> ((statusQ & $past(riseHot)) == $past(riseHot)));

endmodule

bind pin_event_irq pei_checker #(
  .NUM_BANKS(NUM_BANKS), .PORTS_PER_BANK(PORTS_PER_BANK)
) u_check (
  .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .wrEn(wrEn), .wrReg(wrAddr[7:4]),
  .statusQ(statusQ), .enableQ(enableQ), .trigHigh(trigHigh), .trigEdge(trigEdge),
  .trigDelta(trigDelta), .irqOut(irqOut)
);

// File: tb/pin_event_irq_tb.sv
`timescale 1ns/1ps
module pin_event_irq_tb;

  localparam int NB = 2, PPB = 4, AW = 12;
  localparam int NP = NB * PPB * 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] pins;
  logic          wrEn;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [31:0]   wrData, rdData;
  logic [NB-1:0] irq;

  always #2.5 clk = ~clk;

  pin_event_irq #(.NUM_BANKS(NB), .PORTS_PER_BANK(PPB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .pinsIn(pins), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Bench model of the register state.
  logic [NP-1:0] mStat = '0, mEn = '0, mHi = '0, mEd = '0, mDe = '0, mPrev = '0;

  function automatic logic [AW-1:0] ra(int bank, int rg, int port);
    return AW'(bank * 256 + rg * 16 + port * 4);
  endfunction

  function automatic logic [31:0] expRead(logic [AW-1:0] a);
    int bank = int'(a[11:8]), rg = int'(a[7:4]), port = int'(a[3:2]), base;
    logic [31:0] r = '0;
    if (bank >= NB || a[1:0] != 2'b00) return '0;
    base = (bank * PPB + port) * 8;
    for (int j = 0; j < 8; j++) begin
      case (rg)
        'h4, 'hC: r[j] = mStat[base+j];
        'h5, 'hD: r[j] = mEn[base+j];
        'h6, 'hE: begin r[j] = mHi[base+j]; r[8+j] = mEd[base+j]; r[16+j] = mDe[base+j]; end
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [NB-1:0] expIrq();
    logic [NB-1:0] r = '0;
    for (int b = 0; b < NB; b++) r[b] = |(mStat[b*PPB*8 +: PPB*8] & mEn[b*PPB*8 +: PPB*8]);
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [NB-1:0] ei = expIrq();
    logic [31:0]   er = expRead(rdAddr);
    chk(irq == ei, {tag, " irq"}, 32'(irq), 32'(ei));
    chk(rdData == er, {tag, " rdData"}, rdData, er);
  endtask

  // Update the model for the inputs now applied, then advance one cycle.
  task automatic step();
    logic [NP-1:0] ev;
    for (int i = 0; i < NP; i++)
      ev[i] = mEd[i] ? (mDe[i] ? (pins[i] ^ mPrev[i])
                               : (mHi[i] ? (pins[i] & ~mPrev[i]) : (~pins[i] & mPrev[i])))
                     : (mHi[i] ? pins[i] : ~pins[i]);
    if (wrEn && int'(wrAddr[11:8]) < NB && wrAddr[1:0] == 2'b00) begin
      int base = (int'(wrAddr[11:8]) * PPB + int'(wrAddr[3:2])) * 8;
      for (int j = 0; j < 8; j++) begin
        case (int'(wrAddr[7:4]))
          'h4: mStat[base+j] = wrData[j];
          'hC: if (wrData[8+j]) mStat[base+j] = wrData[j];
          'h5: mEn[base+j] = wrData[j];
          'hD: if (wrData[8+j]) mEn[base+j] = wrData[j];
          'h6: begin mHi[base+j] = wrData[j]; mEd[base+j] = wrData[8+j]; mDe[base+j] = wrData[16+j]; end
          'hE: if (wrData[8+j]) begin
                 mHi[base+j] = wrData[j]; mEd[base+j] = wrData[16+j]; mDe[base+j] = wrData[24+j];
               end
          'h7: if (wrData[j]) mStat[base+j] = 1'b0;
          default: ;
        endcase
      end
    end
    mStat = mStat | ev;
    mPrev = pins;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; pins = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    rdAddr = ra(0, 4, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(irq == '0, "R10 irq in reset", 32'(irq), 32'h0);
    chk(rdData == 32'h0, "R10 status in reset", rdData, 32'h0);
    rdAddr = ra(1, 6, 3);
    #0.1;
    chk(rdData == 32'h0, "R10 trigger in reset", rdData, 32'h0);
    rstN = 1'b1;

    // R4 default active-low level latches; R7 no irq while disabled
    rdAddr = ra(0, 4, 0);
    step();
    checkAll("R4 active-low latch R7");

    // R2 trigger readback, rising mode on bank0 port0
    pins = '1;
    rdAddr = ra(0, 6, 0);
    wr(ra(0, 6, 0), 32'h0000_FFFF);
    checkAll("R2 trigger readback");

    // R5 clear
    rdAddr = ra(0, 4, 0);
    wr(ra(0, 7, 0), 32'h0000_00FF);
    checkAll("R5 clear all");
    rdAddr = ra(0, 4, 1);
    wr(ra(0, 7, 1), 32'h0000_000F);
    checkAll("R5 partial clear");
    wr(ra(0, 7, 1), 32'h0000_0000);
    checkAll("R5 zero write no effect");

    // R4 clear overridden by active level
    rdAddr = ra(0, 4, 2);
    pins[23:16] = 8'h00;
    step();
    wr(ra(0, 7, 2), 32'h0000_00FF);
    checkAll("R4 clear overridden");
    pins[23:16] = 8'hFF;
    step();

    // R3 edges on bank0 port0
    rdAddr = ra(0, 4, 0);
    pins[0] = 1'b0; step();
    checkAll("R3 fall ignored in rising mode");
    pins[0] = 1'b1; step();
    checkAll("R3 rising");
    wr(ra(0, 6, 0), 32'h0000_FF00);
    pins[1] = 1'b0; step();
    checkAll("R3 falling");
    wr(ra(0, 6, 0), 32'h00FF_FF00);
    pins[2] = 1'b0; step();
    checkAll("R3 both edges down");
    wr(ra(0, 7, 0), 32'h0000_0004);
    pins[2] = 1'b1; step();
    checkAll("R3 both edges up");

    // R6 event and clear in the same cycle
    pins[3] = 1'b0;
    wr(ra(0, 7, 0), 32'h0000_0008);
    checkAll("R6 event beats clear");

    // R8 and R9 masked enable
    rdAddr = ra(0, 5, 0);
    wr(ra(0, 'hD, 0), 32'h0000_0101);
    checkAll("R8 irq raised R9 masked enable");
    rdAddr = ra(0, 4, 0);
    wr(ra(0, 7, 0), 32'h0000_0001);
    checkAll("R8 irq drops after clear");

    // R9 masked status and trigger
    wr(ra(0, 'hC, 0), 32'h0000_3010);
    checkAll("R9 masked status");
    rdAddr = ra(1, 6, 2);
    wr(ra(1, 'hE, 2), 32'h00F0_F0F0);
    checkAll("R9 masked trigger");

    // R1 unmapped bank and misaligned address
    rdAddr = ra(3, 4, 0);
    wr(ra(3, 6, 0), 32'h00FF_FFFF);
    chk(rdData == 32'h0, "R1 unmapped bank reads zero", rdData, 32'h0);
    checkAll("R1 unmapped bank");
    rdAddr = ra(0, 4, 0);
    wr(ra(0, 4, 0) | AW'(1), 32'h0000_00AA);
    checkAll("R1 misaligned ignored");

    // R2 active-high level on bank1 port3, R8 bank isolation
    rdAddr = ra(1, 4, 3);
    wr(ra(1, 6, 3), 32'h0000_00FF);
    step();
    checkAll("R2 level high");
    wr(ra(1, 5, 3), 32'h0000_0080);
    checkAll("R8 second bank line");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      pins = pins ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      wrEn = ($urandom % 3) == 0;
      begin
        int rgList[7] = '{4, 5, 6, 7, 'hC, 'hD, 'hE};
        int rg = rgList[$urandom % 7];
        if (($urandom % 4) == 0) rg = 7;
        wrAddr = ra($urandom % 3, rg, $urandom % 4);
        if (($urandom % 16) == 0) wrAddr[1:0] = 2'($urandom);
        wrData = $urandom;
        rdAddr = ra($urandom % 3, rgList[$urandom % 7], $urandom % 4);
      end
      step();
      checkAll("R1 R2 R3 R9 random");
    end
    wrEn = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule